// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a segment-relative memory access into a linear address and rules on whether the access may proceed. It holds a small table of segment descriptors. Each descriptor has a base, a limit, a present flag, a privilege level and three rights bits: read, write and execute. A request names a descriptor through a 16-bit selector. The selector also carries a requested privilege level. With it come an offset, the current privilege level of the running code and the kind of access. One cycle later the unit returns either the translated address or a fault with a reason code.

Privilege levels run from 0 to 3, and 0 is the most privileged. The weaker of the current and the requested levels is the numerically larger one, and that level is compared with the descriptor's level. A real-mode request skips the table entirely. It forms a 20-bit address from the 16-bit segment value and the low 16 bits of the offset. Descriptors are loaded through a one-entry-per-cycle write port before they are used.

Top module: `seg_xlate`

## Requirements
- R1: A request sampled at a rising edge with req_valid high produces rsp_valid high for exactly the next cycle. A cycle without a request leaves rsp_valid, rsp_fault and rsp_code at zero and rsp_addr at zero.
- R2: A protected-mode access that passes every check returns rsp_addr = base + offset, modulo 2^32, with rsp_fault low and rsp_code 0.
- R3: The selector is laid out as follows: bits [1:0] hold the requested level, bit 2 is ignored and bits [15:3] hold the descriptor index. An index of NUM_DESC or above faults with code 1.
- R4: A selected descriptor whose present flag is clear faults with code 2.
- R5: An access faults with code 3 when max(current level, requested level) is greater than the descriptor level.
- R6: The access kind is encoded as 0 = read, 1 = write, 2 = execute and 3 = reserved. An access whose kind lacks the matching rights bit faults with code 4, and the reserved kind always does.
- R7: An offset greater than the descriptor limit faults with code 5. An offset equal to the limit is allowed.
- R8: When several checks fail, the code reported is the first of: invalid index (1), not present (2), privilege (3), rights (4), limit (5).
- R9: A real-mode request never faults. It returns ((selector << 4) + offset[15:0]) modulo 2^20 in the low 20 bits, with the upper bits zero.
- R10: Whenever rsp_fault is high, rsp_addr is zero and rsp_code is nonzero. rsp_fault is a single-cycle pulse for each faulting request.
- R11: A request presented in the same cycle as a write to the descriptor it selects is checked against the entry as it was before the write.
- R12: After reset every descriptor is not present and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Descriptor index to write |
| wr_base | input | ADDR_W | Segment base |
| wr_limit | input | ADDR_W | Highest valid offset |
| wr_present | input | 1 | Present flag |
| wr_dpl | input | 2 | Descriptor privilege level |
| wr_rd | input | 1 | Read permitted |
| wr_wr | input | 1 | Write permitted |
| wr_ex | input | 1 | Execute permitted |
| req_valid | input | 1 | Request strobe |
| req_real | input | 1 | Real-mode request, with no checks |
| req_sel | input | 16 | Selector, or the segment value in real mode |
| req_off | input | ADDR_W | Offset |
| req_cpl | input | 2 | Current privilege level |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | ADDR_W | Linear address, zero on a fault |
| rsp_fault | output | 1 | Fault pulse |
| rsp_code | output | 3 | Fault reason, 0 when there is no fault |

## Verification
Every result appears exactly one cycle after its request. The response register is the only stage between the request pins and the outputs, and descriptor writes take effect at the same edge that captures the response. The bench drives each request on a falling edge and holds it across one rising edge. It then samples all four outputs on the following falling edge, clears the request, and checks on later idle cycles that the strobes have dropped. For the write-collision case, the request is placed in the same falling-edge window as the write. A second request one cycle later shows the new entry.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic              wr_present,
  input  logic [1:0]        wr_dpl,
  input  logic              wr_rd,
  input  logic              wr_wr,
  input  logic              wr_ex,
  input  logic              req_valid,
  input  logic              req_real,
  input  logic [15:0]       req_sel,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_fault,
  output logic [2:0]        rsp_code
);
  localparam int REAL_W = 20;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2;
  localparam logic [2:0] F_NONE = 3'd0, F_SEL = 3'd1, F_NP = 3'd2,
                         F_PRIV = 3'd3, F_RIGHTS = 3'd4, F_LIMIT = 3'd5;

  logic [ADDR_W-1:0] t_base  [NUM_DESC];
  logic [ADDR_W-1:0] t_limit [NUM_DESC];
  logic [1:0]        t_dpl   [NUM_DESC];
  logic [NUM_DESC-1:0] t_p, t_rd, t_wr, t_ex;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) begin
        t_base[i]  <= '0;
        t_limit[i] <= '0;
        t_dpl[i]   <= '0;
      end
      t_p  <= '0;
      t_rd <= '0;
      t_wr <= '0;
      t_ex <= '0;
    end else if (wr_en && (32'(wr_idx) < NUM_DESC)) begin
      t_base[wr_idx]  <= wr_base;
      t_limit[wr_idx] <= wr_limit;
      t_dpl[wr_idx]   <= wr_dpl;
      t_p[wr_idx]     <= wr_present;
      t_rd[wr_idx]    <= wr_rd;
      t_wr[wr_idx]    <= wr_wr;
      t_ex[wr_idx]    <= wr_ex;
    end
  end

  logic unused_ti;
  assign unused_ti = req_sel[2];

  logic              idx_ok;
  logic [IDX_W-1:0]  lk;
  logic [1:0]        eff_pl;
  logic              rights_ok;
  logic [2:0]        code;
  logic [REAL_W-1:0] real_addr;
  logic [ADDR_W-1:0] prot_addr;

  assign idx_ok = 32'(req_sel[15:3]) < NUM_DESC;
  assign lk     = idx_ok ? req_sel[3 +: IDX_W] : '0;
  assign eff_pl = (req_cpl > req_sel[1:0]) ? req_cpl : req_sel[1:0];

  always_comb begin
    case (req_kind)
      K_RD:    rights_ok = t_rd[lk];
      K_WR:    rights_ok = t_wr[lk];
      K_EX:    rights_ok = t_ex[lk];
      default: rights_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (req_real)                    code = F_NONE;
    else if (!idx_ok)                code = F_SEL;
    else if (!t_p[lk])               code = F_NP;
    else if (eff_pl > t_dpl[lk])     code = F_PRIV;
    else if (!rights_ok)             code = F_RIGHTS;
    else if (req_off > t_limit[lk])  code = F_LIMIT;
    else                             code = F_NONE;
  end

  assign real_addr = {req_sel, 4'b0000} + {4'b0000, req_off[15:0]};
  assign prot_addr = t_base[lk] + req_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_code  <= F_NONE;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && (code != F_NONE);
      rsp_code  <= req_valid ? code : F_NONE;
      if (!req_valid || code != F_NONE) rsp_addr <= '0;
      else if (req_real)                rsp_addr <= ADDR_W'(real_addr);
      else                              rsp_addr <= prot_addr;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_real,
  input logic [15:0]       req_sel,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              rsp_fault,
  input logic [2:0]        rsp_code
);
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0));
  assert_bad_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_real && 32'(req_sel[15:3]) >= NUM_DESC) |=> (rsp_fault && rsp_code == 3'd1));
  assert_real_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_real) |=> (!rsp_fault && rsp_addr[ADDR_W-1:20] == '0));
  assert_fault_addr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_addr == '0 && rsp_code != 3'd0 && rsp_valid));
  assert_code_needs_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_code != 3'd0) |-> rsp_fault);
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_real(req_real),
  .req_sel(req_sel), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_fault(rsp_fault), .rsp_code(rsp_code));

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_present = 0, wr_rd = 0, wr_wr = 0, wr_ex = 0;
  logic [2:0] wr_idx = 0;
  logic [31:0] wr_base = 0, wr_limit = 0;
  logic [1:0] wr_dpl = 0;
  logic req_valid = 0, req_real = 0;
  logic [15:0] req_sel = 0;
  logic [31:0] req_off = 0;
  logic [1:0] req_cpl = 0, req_kind = 0;
  logic rsp_valid, rsp_fault;
  logic [31:0] rsp_addr;
  logic [2:0] rsp_code;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  seg_xlate u_seg_xlate (.*);

  function automatic logic [15:0] sel(int idx, bit ti, logic [1:0] rpl);
    return {13'(idx), ti, rpl};
  endfunction

  task automatic chk(string tag, logic v, logic f, logic [2:0] c, logic [31:0] a);
    tests++;
    if (rsp_valid !== v || rsp_fault !== f || rsp_code !== c || rsp_addr !== a) begin
      fails++;
      $display("FAIL %s: got v=%0b f=%0b c=%0d a=%h, expected v=%0b f=%0b c=%0d a=%h",
               tag, rsp_valid, rsp_fault, rsp_code, rsp_addr, v, f, c, a);
    end
  endtask

  task automatic wr(int idx, logic [31:0] b, logic [31:0] l, bit p, logic [1:0] d,
                    bit r, bit w, bit x);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_base = b; wr_limit = l; wr_present = p;
    wr_dpl = d; wr_rd = r; wr_wr = w; wr_ex = x;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rq(bit rm, logic [15:0] s, logic [31:0] o, logic [1:0] cpl, logic [1:0] k);
    @(negedge clk);
    req_valid = 1; req_real = rm; req_sel = s; req_off = o; req_cpl = cpl; req_kind = k;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset;
    chk("R12 reset outputs", 0, 0, 0, 0);
    rq(0, sel(0, 0, 0), 0, 0, 0);
    chk("R12 entry absent after reset", 1, 1, 2, 0);
    @(negedge clk);
    chk("R1 idle after response", 0, 0, 0, 0);
  endtask

  task automatic t_load;
    wr(0, 32'h0001_0000, 32'h0000_0FFF, 1, 3, 1, 1, 0);
    wr(1, 32'h8000_0000, 32'h0000_FFFF, 1, 0, 1, 0, 1);
    wr(2, 32'h0000_2000, 32'h0000_0100, 1, 2, 1, 0, 0);
    wr(3, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0, 1, 1, 1);
    wr(5, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 1, 3, 1, 0, 0);
  endtask

  task automatic t_translate;
    rq(0, sel(0, 0, 3), 32'h123, 3, 0);
    chk("R2 read data segment", 1, 0, 0, 32'h0001_0123);
    rq(0, sel(0, 0, 3), 32'h0FF, 3, 1);
    chk("R2 write data segment", 1, 0, 0, 32'h0001_00FF);
    rq(0, sel(1, 0, 0), 32'h10, 0, 2);
    chk("R2 execute code segment", 1, 0, 0, 32'h8000_0010);
    rq(0, sel(5, 0, 3), 32'h20, 3, 0);
    chk("R2 address wraps", 1, 0, 0, 32'h0000_0010);
  endtask

  task automatic t_selector;
    rq(0, sel(9, 0, 0), 0, 0, 0);
    chk("R3 index beyond table", 1, 1, 1, 0);
    rq(0, sel(8, 1, 0), 0, 0, 0);
    chk("R3 first index past end", 1, 1, 1, 0);
    rq(0, sel(0, 1, 3), 32'h4, 3, 0);
    chk("R3 table bit ignored", 1, 0, 0, 32'h0001_0004);
    rq(0, sel(3, 0, 0), 0, 0, 0);
    chk("R4 not present", 1, 1, 2, 0);
  endtask

  task automatic t_priv;
    rq(0, sel(1, 0, 1), 0, 0, 0);
    chk("R5 requested level weaker", 1, 1, 3, 0);
    rq(0, sel(1, 0, 0), 0, 1, 0);
    chk("R5 current level weaker", 1, 1, 3, 0);
    rq(0, sel(2, 0, 2), 32'h8, 2, 0);
    chk("R5 equal levels allowed", 1, 0, 0, 32'h0000_2008);
    rq(0, sel(2, 0, 0), 32'h8, 2, 0);
    chk("R5 max uses current level", 1, 0, 0, 32'h0000_2008);
    rq(0, sel(2, 0, 3), 32'h8, 2, 0);
    chk("R5 rpl 3 vs dpl 2", 1, 1, 3, 0);
  endtask

  task automatic t_rights;
    rq(0, sel(2, 0, 2), 32'h8, 2, 1);
    chk("R6 write to read-only", 1, 1, 4, 0);
    rq(0, sel(1, 0, 0), 32'h8, 0, 1);
    chk("R6 write to code", 1, 1, 4, 0);
    rq(0, sel(0, 0, 3), 32'h8, 3, 2);
    chk("R6 execute data", 1, 1, 4, 0);
    rq(0, sel(0, 0, 3), 32'h8, 3, 3);
    chk("R6 reserved kind", 1, 1, 4, 0);
  endtask

  task automatic t_limit;
    rq(0, sel(2, 0, 2), 32'h100, 2, 0);
    chk("R7 offset equals limit", 1, 0, 0, 32'h0000_2100);
    rq(0, sel(2, 0, 2), 32'h101, 2, 0);
    chk("R7 offset past limit", 1, 1, 5, 0);
    @(negedge clk);
    chk("R10 fault is one pulse", 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    rq(0, sel(1, 0, 3), 32'h0002_0000, 3, 1);
    chk("R8 privilege before rights and limit", 1, 1, 3, 0);
    rq(0, sel(2, 0, 2), 32'h200, 2, 1);
    chk("R8 rights before limit", 1, 1, 4, 0);
    rq(0, sel(3, 0, 3), 32'h0, 3, 3);
    chk("R8 absent before privilege", 1, 1, 2, 0);
  endtask

  task automatic t_real;
    rq(1, 16'h1234, 32'h5678, 3, 1);
    chk("R9 real mode address", 1, 0, 0, 32'h0001_79B8);
    rq(1, 16'hFFFF, 32'h0020, 3, 3);
    chk("R9 real mode wraps 20 bits", 1, 0, 0, 32'h0000_0010);
    rq(1, 16'h0001, 32'hABCD_0010, 0, 2);
    chk("R9 upper offset ignored", 1, 0, 0, 32'h0000_0020);
  endtask

  task automatic t_collide;
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd2; wr_base = 32'h0009_0000; wr_limit = 32'hFFFF;
    wr_present = 1; wr_dpl = 3; wr_rd = 1; wr_wr = 1; wr_ex = 0;
    req_valid = 1; req_real = 0; req_sel = sel(2, 0, 3); req_off = 32'h10;
    req_cpl = 3; req_kind = 1;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    chk("R11 same-cycle request sees old entry", 1, 1, 3, 0);
    rq(0, sel(2, 0, 3), 32'h10, 3, 1);
    chk("R11 next request sees new entry", 1, 0, 0, 32'h0009_0010);
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_load();
    t_translate();
    t_selector();
    t_priv();
    t_rights();
    t_limit();
    t_priority();
    t_real();
    t_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    #(5.0 * 20000);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end
endmodule